// File: doc/BRIEF.md
# Register-Mapped Single-Frame Network Buffer

This block sits between a host register window and a simple byte-stream network line. It holds one receive frame and one transmit frame. The host reaches both through a byte-addressed window of 32-bit registers. Frame bytes move one at a time through two data ports whose pointers advance by themselves. A separate pair of count registers tells the host how many received bytes remain, and how many transmit bytes the next frame will carry. The host writes a transmit length and then that many bytes. The write that reaches the length launches the frame onto the output stream without any further command. A received frame is accepted only while the block is not busy and its receive buffer has room. Two event flags, transmit-done and receive-done, drive the interrupt line. The host clears them through the interrupt control register, and that write also recomputes the busy flag.

The receive side runs the machine `rx_state_e`. It has three states: `RX_IDLE` (waiting for a first byte), `RX_FILL` (storing an accepted frame) and `RX_SKIP` (discarding a refused frame). It has four transitions:
- `RX_IDLE` to `RX_FILL` on a first byte that is not last, while accepting.
- `RX_IDLE` to `RX_SKIP` on a first byte that is not last, while refusing.
- `RX_FILL` to `RX_IDLE` on a last byte.
- `RX_SKIP` to `RX_IDLE` on a last byte.

A one-byte frame stays in `RX_IDLE`. The transmit side runs `tx_state_e`, which has two states: `TX_COLLECT` (host fills the buffer) and `TX_SEND` (the frame streams out). `TX_COLLECT` goes to `TX_SEND` on the data write that reaches the programmed length. `TX_SEND` goes back to `TX_COLLECT` when the last byte is taken.

Top module: `netbuf_top`

## Requirements
- R1: Only address bits 5:0 are decoded. Offset 0x00 reads 0x4D495053 and offset 0x04 reads 0x4E455430. An address of 0x40 or 0x44 therefore aliases these two.
- R2: After reset, busy (offset 0x08, bit 0) reads 1. The receive count (0x0C) and transmit count (0x10) read 0. The interrupt control register (0x14) reads 0, `irq` is low, `rx_ready` is low and `tx_valid` is low.
- R3: A write to 0x10 loads the transmit count with the written value, or with 0 if the value exceeds MAX_FRAME. It also resets the transmit write pointer to 0. Such a write has no effect while a frame is streaming out.
- R4: A write to 0x20 stores bits 7:0 at the write pointer and advances the pointer. When the pointer reaches the count, the frame is launched, the count clears, transmit-done (0x14 bit 0) sets and busy becomes 1. A write to 0x20 while the count is 0 is ignored.
- R5: A launched frame appears on `tx_data` in write order with `tx_valid` high. `tx_last` marks the final byte. Each byte holds stable until `tx_ready` is high.
- R6: `rx_ready` is high only when busy is 0 and the receive count is below MAX_FRAME. A frame whose first byte arrives while `rx_ready` is low is discarded up to its last byte and leaves all registers unchanged.
- R7: When an accepted frame ends, the receive count becomes the frame length and the read pointer returns to 0. Busy becomes 1 and receive-done (0x14 bit 1) sets.
- R8: A read of 0x1C with a nonzero receive count returns the next stored byte in bits 7:0, advances the pointer and decrements the count. With a zero count it returns 0 and changes nothing.
- R9: A write to 0x14 with bit 0 set clears transmit-done. Otherwise, bit 1 set clears receive-done. After either, busy becomes the OR of the remaining flags. `irq` is high exactly when a flag is set.
- R10: Offsets 0x18, 0x20 and all undefined offsets read 0. Writes to 0x00, 0x04, 0x08, 0x0C, 0x18 and 0x1C have no effect.
- R11: Read data appears on `host_rdata` with `host_rvalid` high one cycle after `host_rd`.
- R12: Bytes of a received frame beyond MAX_FRAME are dropped. The receive count saturates at MAX_FRAME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| host_rvalid | output | 1 | Read data valid |
| rx_valid | input | 1 | Line receive byte valid |
| rx_data | input | 8 | Line receive byte |
| rx_last | input | 1 | Final byte of the received frame |
| rx_ready | output | 1 | A frame starting now would be accepted |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmitted frame |
| tx_ready | input | 1 | Line takes the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer shows up at the data ports on the very next byte. A receive pointer that is off by one returns a neighbouring byte on the next read of 0x1C. A transmit pointer that is off by one either launches the frame one write early or late, or shifts every streamed byte. A wrong count or a stale busy flag shows at `rx_ready` immediately, and in the count registers one read later. A flag that fails to set or clear is visible on `irq` in the cycle after the event. The bench sweeps every frame length from 1 to beyond the buffer size in both directions, and compares each byte against a value computed from the frame index.

// File: rtl/netbuf_pkg.sv
package netbuf_pkg;

    localparam logic [5:0] OFS_SIG_HI   = 6'h00;
    localparam logic [5:0] OFS_SIG_LO   = 6'h04;
    localparam logic [5:0] OFS_BUSY     = 6'h08;
    localparam logic [5:0] OFS_RX_CNT   = 6'h0C;
    localparam logic [5:0] OFS_TX_CNT   = 6'h10;
    localparam logic [5:0] OFS_IRQ_CTL  = 6'h14;
    localparam logic [5:0] OFS_IRQ_INFO = 6'h18;
    localparam logic [5:0] OFS_RX_PORT  = 6'h1C;
    localparam logic [5:0] OFS_TX_PORT  = 6'h20;

    localparam logic [31:0] SIG_WORD_HI = 32'h4D49_5053;
    localparam logic [31:0] SIG_WORD_LO = 32'h4E45_5430;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_FILL,
        RX_SKIP
    } rx_state_e;

    typedef enum logic {
        TX_COLLECT,
        TX_SEND
    } tx_state_e;

    typedef struct packed {
        logic rx_done;
        logic tx_done;
    } evt_flags_t;

endpackage

// File: rtl/netbuf_rx.sv
module netbuf_rx
    import netbuf_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    input  logic             pop_i,
    output logic [7:0]       pop_byte_o,
    output logic [CNT_W-1:0] count_o,
    output logic             commit_o
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);

    rx_state_e        state, state_nx;
    logic [7:0]       mem [MAX_FRAME];
    logic [CNT_W-1:0] wptr, rptr, count;
    logic [CNT_W-1:0] wptr_eff, len_nx;
    logic             take, store_en, commit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: if (in_valid && !in_last) state_nx = accept_i ? RX_FILL : RX_SKIP;
            RX_FILL: if (in_valid && in_last)  state_nx = RX_IDLE;
            RX_SKIP: if (in_valid && in_last)  state_nx = RX_IDLE;
            default: state_nx = RX_IDLE;
        endcase
    end

    // outputs of the machine
    always_comb begin
        in_ready = 1'b0;
        take     = 1'b0;
        unique case (state)
            RX_IDLE: begin
                in_ready = accept_i;
                take     = in_valid && accept_i;
            end
            RX_FILL: begin
                in_ready = 1'b1;
                take     = in_valid;
            end
            RX_SKIP: begin
                in_ready = 1'b0;
                take     = 1'b0;
            end
            default: begin
                in_ready = 1'b0;
                take     = 1'b0;
            end
        endcase
        wptr_eff = (state == RX_IDLE) ? '0 : wptr;
        len_nx   = (wptr_eff == MAX_C) ? MAX_C : wptr_eff + CNT_W'(1);
        store_en = take && (wptr_eff != MAX_C);
        commit   = take && in_last;
    end

    always_ff @(posedge clk) begin
        if (store_en) mem[wptr_eff] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (take) wptr <= len_nx;
            if (commit) begin
                count <= len_nx;
                rptr  <= '0;
            end else if (pop_i && count != '0) begin
                count <= count - CNT_W'(1);
                rptr  <= rptr + CNT_W'(1);
            end
        end
    end

    assign pop_byte_o = mem[rptr];
    assign count_o    = count;
    assign commit_o   = commit;

    p_rx_count_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= MAX_C);

    p_pop_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && count_o != '0 && !commit_o) |=> count_o == $past(count_o) - CNT_W'(1));

    p_commit_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> count_o != '0);

    p_skip_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_SKIP) |-> !commit_o);

endmodule

// File: rtl/netbuf_tx.sv
module netbuf_tx
    import netbuf_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr_i,
    input  logic             data_wr_i,
    input  logic [31:0]      wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fire_o,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);

    tx_state_e        state, state_nx;
    logic [7:0]       mem [MAX_FRAME];
    logic [CNT_W-1:0] count, wptr, len, rptr;
    logic             fire, store_en, at_last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_COLLECT;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            TX_COLLECT: if (fire)                state_nx = TX_SEND;
            TX_SEND:    if (out_ready && at_last) state_nx = TX_COLLECT;
            default:    state_nx = TX_COLLECT;
        endcase
    end

    // outputs of the machine
    always_comb begin
        store_en  = 1'b0;
        fire      = 1'b0;
        out_valid = 1'b0;
        at_last   = (rptr == len - CNT_W'(1));
        unique case (state)
            TX_COLLECT: begin
                store_en = data_wr_i && (count != '0);
                fire     = store_en && (wptr + CNT_W'(1) == count);
            end
            TX_SEND: begin
                out_valid = 1'b1;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (store_en) mem[wptr] <= wdata_i[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            wptr  <= '0;
            len   <= '0;
            rptr  <= '0;
        end else if (state == TX_COLLECT) begin
            if (cnt_wr_i) begin
                count <= (wdata_i <= 32'(MAX_FRAME)) ? wdata_i[CNT_W-1:0] : '0;
                wptr  <= '0;
            end else if (fire) begin
                len   <= count;
                count <= '0;
                wptr  <= '0;
                rptr  <= '0;
            end else if (store_en) begin
                wptr  <= wptr + CNT_W'(1);
            end
        end else if (out_ready) begin
            rptr <= rptr + CNT_W'(1);
        end
    end

    assign count_o  = count;
    assign fire_o   = fire;
    assign out_data = mem[rptr];
    assign out_last = out_valid && at_last;

    p_tx_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= MAX_C);

    p_send_ignores_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cnt_wr_i) |=> count_o == '0);

    p_fire_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (count_o == '0) && out_valid);

    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

endmodule

// File: rtl/netbuf_ctrl.sv
module netbuf_ctrl
    import netbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_commit_i,
    input  logic       tx_fire_i,
    input  logic       irq_wr_i,
    input  logic [1:0] irq_wdata_i,
    output evt_flags_t flags_o,
    output logic       busy_o,
    output logic       irq_o
);

    evt_flags_t flags, flags_nx, clr;
    logic       busy, busy_nx;

    always_comb begin
        clr = '0;
        if (irq_wr_i) begin
            if (irq_wdata_i[0])      clr.tx_done = 1'b1;
            else if (irq_wdata_i[1]) clr.rx_done = 1'b1;
        end
        flags_nx         = flags & ~clr;
        flags_nx.tx_done = flags_nx.tx_done | tx_fire_i;
        flags_nx.rx_done = flags_nx.rx_done | rx_commit_i;
        if (rx_commit_i || tx_fire_i) busy_nx = 1'b1;
        else if (irq_wr_i)            busy_nx = |flags_nx;
        else                          busy_nx = busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            busy  <= 1'b1;
        end else begin
            flags <= flags_nx;
            busy  <= busy_nx;
        end
    end

    assign flags_o = flags;
    assign busy_o  = busy;
    assign irq_o   = |flags;

    p_busy_rx_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_commit_i |=> busy_o && flags_o.rx_done);

    p_busy_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire_i |=> busy_o && flags_o.tx_done);

    p_clear_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_wr_i && irq_wdata_i[0] && !tx_fire_i) |=> !flags_o.tx_done);

endmodule

// File: rtl/netbuf_top.sv
module netbuf_top
    import netbuf_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_rvalid,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic              irq
);

    localparam int               CNT_W = $clog2(MAX_FRAME + 1);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_FRAME);

    logic [5:0]       ofs;
    logic [CNT_W-1:0] rx_count, tx_count;
    logic [7:0]       rx_byte;
    logic             rx_commit, tx_fire, busy, accept, pop;
    evt_flags_t       flags;
    logic [31:0]      rd_mux;

    assign ofs = host_addr[5:0];

    generate
        if (ADDR_W > 6) begin : g_addr_hi
            logic unused_addr_hi;
            assign unused_addr_hi = ^host_addr[ADDR_W-1:6];
        end
    endgenerate

    assign accept = !busy && (rx_count < MAX_C);
    assign pop    = host_rd && (ofs == OFS_RX_PORT);

    netbuf_rx #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .in_valid   (rx_valid),
        .in_data    (rx_data),
        .in_last    (rx_last),
        .in_ready   (rx_ready),
        .pop_i      (pop),
        .pop_byte_o (rx_byte),
        .count_o    (rx_count),
        .commit_o   (rx_commit)
    );

    netbuf_tx #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr_i  (host_wr && (ofs == OFS_TX_CNT)),
        .data_wr_i (host_wr && (ofs == OFS_TX_PORT)),
        .wdata_i   (host_wdata),
        .count_o   (tx_count),
        .fire_o    (tx_fire),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .out_ready (tx_ready)
    );

    netbuf_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_commit_i (rx_commit),
        .tx_fire_i   (tx_fire),
        .irq_wr_i    (host_wr && (ofs == OFS_IRQ_CTL)),
        .irq_wdata_i (host_wdata[1:0]),
        .flags_o     (flags),
        .busy_o      (busy),
        .irq_o       (irq)
    );

    always_comb begin
        case (ofs)
            OFS_SIG_HI:  rd_mux = SIG_WORD_HI;
            OFS_SIG_LO:  rd_mux = SIG_WORD_LO;
            OFS_BUSY:    rd_mux = {31'b0, busy};
            OFS_RX_CNT:  rd_mux = 32'(rx_count);
            OFS_TX_CNT:  rd_mux = 32'(tx_count);
            OFS_IRQ_CTL: rd_mux = {30'b0, flags.rx_done, flags.tx_done};
            OFS_RX_PORT: rd_mux = (rx_count != '0) ? {24'b0, rx_byte} : 32'b0;
            default:     rd_mux = 32'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            if (host_rd) host_rdata <= rd_mux;
        end
    end

    p_ready_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(rx_ready && !rx_valid));

    p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);

endmodule

// File: tb/netbuf_top_tb_top.sv
module netbuf_top_tb_top;

    localparam int MAXF = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic        rx_valid = 1'b0, rx_last = 1'b0, rx_ready;
    logic [7:0]  rx_data = '0;
    logic        tx_valid, tx_last, tx_ready = 1'b0, irq;
    logic [7:0]  tx_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    netbuf_top #(.MAX_FRAME(MAXF), .ADDR_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 31 + i * 7 + 3) & 255);
    endfunction

    task automatic host_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic expect_reg(logic [7:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        check("R11 rvalid", {31'b0, host_rvalid}, 32'd1);
        check(req, host_rdata, exp);
    endtask

    task automatic rx_frame(int n, int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = pat(seed, i); rx_last = (i == n - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic tx_send_check(int n, int seed, bit poke);
        host_write(8'h10, n);
        for (int i = 0; i < n; i++) host_write(8'h20, {24'hA5C3E1, pat(seed, i)});
        check("R5 valid after launch", {31'b0, tx_valid}, 32'd1);
        check("R5 first byte", {24'b0, tx_data}, {24'b0, pat(seed, 0)});
        if (poke) host_write(8'h10, 32'd5);
        else @(negedge clk);
        check("R5 hold while stalled", {24'b0, tx_data}, {24'b0, pat(seed, 0)});
        tx_ready = 1'b1;
        for (int i = 0; i < n; i++) begin
            check("R5 stream valid", {31'b0, tx_valid}, 32'd1);
            check("R5 stream byte", {24'b0, tx_data}, {24'b0, pat(seed, i)});
            check("R5 stream last", {31'b0, tx_last}, {31'b0, i == n - 1});
            @(negedge clk);
        end
        tx_ready = 1'b0;
        check("R5 idle after frame", {31'b0, tx_valid}, 32'd0);
        if (poke) expect_reg(8'h10, 32'd0, "R3 count write ignored while sending");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check("R2 irq", {31'b0, irq}, 32'd0);
        check("R2 rx_ready", {31'b0, rx_ready}, 32'd0);
        check("R2 tx_valid", {31'b0, tx_valid}, 32'd0);
        expect_reg(8'h08, 32'd1, "R2 busy");
        expect_reg(8'h0C, 32'd0, "R2 rx count");
        expect_reg(8'h10, 32'd0, "R2 tx count");
        expect_reg(8'h14, 32'd0, "R2 flags");

        // R1 signature and aliasing
        expect_reg(8'h00, 32'h4D495053, "R1 sig0");
        expect_reg(8'h04, 32'h4E455430, "R1 sig1");
        expect_reg(8'h40, 32'h4D495053, "R1 alias0");
        expect_reg(8'h44, 32'h4E455430, "R1 alias1");

        // R10 zero reads
        expect_reg(8'h18, 32'd0, "R10 irq info");
        expect_reg(8'h20, 32'd0, "R10 tx port");
        expect_reg(8'h24, 32'd0, "R10 undefined");
        expect_reg(8'h3C, 32'd0, "R10 undefined high");

        // R9 write 0 recomputes busy
        host_write(8'h14, 32'd0);
        expect_reg(8'h08, 32'd0, "R9 busy after ack");
        check("R6 ready when idle", {31'b0, rx_ready}, 32'd1);

        // R10 ignored writes
        host_write(8'h08, 32'd1);
        expect_reg(8'h08, 32'd0, "R10 busy write ignored");
        host_write(8'h0C, 32'd5);
        expect_reg(8'h0C, 32'd0, "R10 rx count write ignored");
        host_write(8'h00, 32'hFFFF_FFFF);
        host_write(8'h18, 32'hFFFF_FFFF);
        host_write(8'h1C, 32'hFFFF_FFFF);
        expect_reg(8'h00, 32'h4D495053, "R10 sig write ignored");
        expect_reg(8'h0C, 32'd0, "R10 rx port write ignored");
        check("R10 irq unchanged", {31'b0, irq}, 32'd0);

        // R8 empty read
        expect_reg(8'h1C, 32'd0, "R8 empty read");
        expect_reg(8'h0C, 32'd0, "R8 empty read no change");

        // R3 count limits
        host_write(8'h10, MAXF + 1);
        expect_reg(8'h10, 32'd0, "R3 over max");
        host_write(8'h10, 32'hFFFF_FFFF);
        expect_reg(8'h10, 32'd0, "R3 huge");
        host_write(8'h10, MAXF);
        expect_reg(8'h10, MAXF, "R3 at max");
        host_write(8'h10, 32'd0);
        expect_reg(8'h10, 32'd0, "R3 zero");

        // R4 data write with count 0 ignored
        host_write(8'h20, 32'h55);
        check("R4 no launch at zero count", {31'b0, tx_valid}, 32'd0);
        check("R4 no flag at zero count", {31'b0, irq}, 32'd0);
        expect_reg(8'h08, 32'd0, "R4 busy unchanged at zero count");

        // R3 pointer reset by count rewrite
        host_write(8'h10, 32'd4);
        for (int i = 0; i < 3; i++) host_write(8'h20, 32'hEE);
        expect_reg(8'h10, 32'd4, "R3 count kept during fill");
        tx_send_check(4, 200, 1'b0);
        host_write(8'h14, 32'd1);

        // R4/R5 sweep of all lengths
        for (int n = 1; n <= MAXF; n++) begin
            tx_send_check(n, n, n == 3);
            check("R4 irq after launch", {31'b0, irq}, 32'd1);
            expect_reg(8'h14, 32'd1, "R4 tx done flag");
            expect_reg(8'h08, 32'd1, "R4 busy after launch");
            expect_reg(8'h10, 32'd0, "R4 count cleared");
            host_write(8'h14, 32'd1);
            expect_reg(8'h14, 32'd0, "R9 tx done cleared");
            expect_reg(8'h08, 32'd0, "R9 busy cleared");
            check("R9 irq low", {31'b0, irq}, 32'd0);
        end

        // R6/R7/R8/R12 receive sweep
        for (int n = 1; n <= MAXF + 2; n++) begin
            int exp_n;
            exp_n = (n < MAXF) ? n : MAXF;
            check("R6 ready before frame", {31'b0, rx_ready}, 32'd1);
            rx_frame(n, n + 50);
            check("R7 ready drops", {31'b0, rx_ready}, 32'd0);
            check("R7 irq", {31'b0, irq}, 32'd1);
            expect_reg(8'h0C, exp_n, "R7 R12 count");
            expect_reg(8'h14, 32'd2, "R7 rx done");
            expect_reg(8'h08, 32'd1, "R7 busy");
            host_write(8'h14, 32'd2);
            expect_reg(8'h08, 32'd0, "R9 busy after rx ack");
            if (exp_n == MAXF) begin
                check("R6 full buffer refuses", {31'b0, rx_ready}, 32'd0);
                rx_frame(3, 99);
                expect_reg(8'h14, 32'd0, "R6 full drop no flag");
                expect_reg(8'h0C, MAXF, "R6 full drop count");
            end
            for (int i = 0; i < exp_n; i++)
                expect_reg(8'h1C, {24'b0, pat(n + 50, i)}, "R8 rx byte");
            expect_reg(8'h1C, 32'd0, "R8 read past end");
            expect_reg(8'h0C, 32'd0, "R8 count drained");
        end

        // R6 drop while busy
        rx_frame(4, 7);
        check("R6 busy refuses", {31'b0, rx_ready}, 32'd0);
        rx_frame(5, 8);
        expect_reg(8'h0C, 32'd4, "R6 busy drop count");
        expect_reg(8'h1C, {24'b0, pat(7, 0)}, "R6 first frame kept");
        expect_reg(8'h0C, 32'd3, "R8 decrement");
        for (int i = 1; i < 4; i++)
            expect_reg(8'h1C, {24'b0, pat(7, i)}, "R6 first frame kept");
        host_write(8'h14, 32'd2);

        // R9 priority
        rx_frame(3, 9);
        tx_send_check(2, 77, 1'b0);
        expect_reg(8'h14, 32'd3, "R9 both flags");
        host_write(8'h14, 32'd3);
        expect_reg(8'h14, 32'd2, "R9 tx first");
        expect_reg(8'h08, 32'd1, "R9 busy held by rx flag");
        host_write(8'h14, 32'd2);
        expect_reg(8'h14, 32'd0, "R9 rx cleared");
        expect_reg(8'h08, 32'd0, "R9 busy low");
        check("R9 irq low at end", {31'b0, irq}, 32'd0);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule